// File: doc/BRIEF.md
# Link negotiation and keepalive responder

This block sits behind a serial host link and answers the two housekeeping requests a host sends before and during normal traffic: the link negotiation request and the keepalive probe. A framing stage ahead of it stores each received packet in a buffer and presents the packet's type code and total byte count with a valid/ready handshake. The responder walks the stored bytes through an asynchronous read port, checks them, and writes a fixed-format reply (a type byte, a body length byte, then the body) into an outbound byte stream with valid/ready flow control.

A request that fails its check is dropped without a reply and marked by a one-cycle error pulse. Event packets, which only a controller may send, are flagged the same way, as is any unknown type code. Command, asynchronous data and synchronous data packets belong to other blocks and are retired silently. A packet is retired (ready pulsed) only after its whole reply has left the output stream, so at most one reply is in flight.

Top module: `link_hs_responder`

## Requirements
- R1: After reset, out_valid, pkt_ready and err_pulse are all low.
- R2: A packet with type code 0x06 whose length is 12 and whose buffered bytes 0 to 11 equal 06 0A 00 A0 01 00 00 4C 00 96 00 00 is answered with the 12 bytes 06, 0A, 20, buffered bytes 3 to 9 in ascending order, FF, FF.
- R3: A type 0x06 packet whose length is not 12, or whose buffered bytes differ from that pattern in any position (byte 0 included), produces no reply and one error pulse.
- R4: A type 0x07 packet of length 4 with buffered byte 2 equal to 0x55 and byte 3 equal to 0x00 is answered with the bytes 07 02 CC 00; buffered bytes 0 and 1 are not checked.
- R5: A type 0x07 packet with another length, or with byte 2 not 0x55, or byte 3 not 0x00, produces no reply and one error pulse.
- R6: Type 0x04 (event) and any type code other than 0x01, 0x02, 0x03, 0x06, 0x07 produce one error pulse and no reply; types 0x01, 0x02 and 0x03 are retired with no reply and no error pulse.
- R7: err_pulse is high for exactly one cycle per rejected packet and never while out_valid is high.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R9: pkt_ready is high for one cycle per packet, only after the last reply byte has been accepted, never while out_valid is high.
- R10: rd_addr never exceeds 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A buffered packet is presented |
| pkt_ready | output | 1 | Packet retired (handshake completes) |
| pkt_type | input | 8 | Type code of the presented packet |
| pkt_len | input | LEN_W | Total packet length in bytes, type byte included |
| rd_addr | output | ADDR_W | Byte address into the packet buffer |
| rd_data | input | 8 | Buffer byte at rd_addr, same cycle |
| out_valid | output | 1 | Reply byte available |
| out_ready | input | 1 | Downstream accepts the reply byte |
| out_data | output | 8 | Reply byte |
| err_pulse | output | 1 | One-cycle flag for a rejected packet |

## Verification
The hardest situation to reach is a long reply stalled mid-stream while the packet interface still holds the request: the bench drives out_ready from a pseudo-random sequence and also holds it low for stretches, so negotiation replies are frozen at varying byte positions while the retire pulse must wait. Single-byte corruptions at several positions of the negotiation pattern, including the type byte in the buffer and a length one short, exercise each compare step of the scan rather than only its first and last bytes. The keepalive case with an arbitrary second byte shows that bytes outside the checked window leave the reply unchanged.

// File: rtl/link_hs_pkg.sv
package link_hs_pkg;

   typedef enum logic {K_NEG = 1'b0, K_KA = 1'b1} req_kind_t;

   // packet type codes seen on the host link
   localparam logic [7:0] PT_CMD = 8'h01;
   localparam logic [7:0] PT_ACL = 8'h02;
   localparam logic [7:0] PT_SCO = 8'h03;
   localparam logic [7:0] PT_EVT = 8'h04;
   localparam logic [7:0] PT_NEG = 8'h06;
   localparam logic [7:0] PT_KA  = 8'h07;

   // request and reply geometry
   localparam int NEG_BYTES   = 12;
   localparam int KA_BYTES    = 4;
   localparam int ECHO_FIRST  = 3;
   localparam int ECHO_BYTES  = 7;
   localparam int IDX_W       = $clog2(NEG_BYTES);

   localparam logic [7:0] RPL_NEG_TAG = 8'h20;
   localparam logic [7:0] RPL_PAD     = 8'hFF;
   localparam logic [7:0] RPL_KA_ACK  = 8'hCC;
   localparam logic [7:0] KA_MAGIC    = 8'h55;

   // expected negotiation request, byte by byte
   function automatic logic [7:0] neg_pattern(input logic [IDX_W-1:0] i);
      logic [7:0] b;
      case (i)
         4'd0:    b = PT_NEG;
         4'd1:    b = 8'h0A;
         4'd3:    b = 8'hA0;
         4'd4:    b = 8'h01;
         4'd7:    b = 8'h4C;
         4'd9:    b = 8'h96;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

   // keepalive: only bytes 2 and 3 take part in the check
   function automatic logic ka_byte_ok(input logic [IDX_W-1:0] i,
                                       input logic [7:0] d);
      logic ok;
      case (i)
         4'd2:    ok = (d == KA_MAGIC);
         4'd3:    ok = (d == 8'h00);
         default: ok = 1'b1;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/link_hs_scan.sv
module link_hs_scan
   import link_hs_pkg::*;
#(
   parameter int LEN_W  = 13,
   parameter int ADDR_W = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  req_kind_t                       kind,
   input  logic [LEN_W-1:0]                len,
   output logic [ADDR_W-1:0]               rd_addr,
   input  logic [7:0]                      rd_data,
   output logic                            done,
   output logic                            good,
   output logic [ECHO_BYTES-1:0][7:0]      echo
);

   localparam logic [LEN_W-1:0] NEG_LEN  = LEN_W'(NEG_BYTES);
   localparam logic [LEN_W-1:0] KA_LEN   = LEN_W'(KA_BYTES);
   localparam logic [IDX_W-1:0] NEG_LAST = IDX_W'(NEG_BYTES - 1);
   localparam logic [IDX_W-1:0] KA_LAST  = IDX_W'(KA_BYTES - 1);

   logic             run;
   logic             bad;
   logic [IDX_W-1:0] idx;
   req_kind_t        kind_q;
   logic             byte_ok;
   logic [IDX_W-1:0] last_idx;
   logic [LEN_W-1:0] want_len;

   assign want_len = (kind == K_NEG) ? NEG_LEN : KA_LEN;
   assign last_idx = (kind_q == K_NEG) ? NEG_LAST : KA_LAST;
   assign rd_addr  = ADDR_W'(idx);

   always_comb begin
      if (kind_q == K_NEG) byte_ok = (rd_data == neg_pattern(idx));
      else                 byte_ok = ka_byte_ok(idx, rd_data);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         bad    <= 1'b0;
         idx    <= '0;
         kind_q <= K_NEG;
         done   <= 1'b0;
         good   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            kind_q <= kind;
            idx    <= '0;
            bad    <= 1'b0;
            if (len != want_len) begin
               done <= 1'b1;
               good <= 1'b0;
               run  <= 1'b0;
            end else begin
               run <= 1'b1;
            end
         end else if (run) begin
            bad <= bad | ~byte_ok;
            if (idx == last_idx) begin
               run  <= 1'b0;
               done <= 1'b1;
               good <= ~(bad | ~byte_ok);
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   // one capture register per echoed byte
   for (genvar g = 0; g < ECHO_BYTES; g++) begin : g_cap
      logic [7:0] cap_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cap_q <= '0;
         else if (run && kind_q == K_NEG && idx == IDX_W'(ECHO_FIRST + g))
            cap_q <= rd_data;
      end
      assign echo[g] = cap_q;
   end

endmodule

// File: rtl/link_hs_reply.sv
module link_hs_reply
   import link_hs_pkg::*;
(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  req_kind_t                  kind,
   input  logic [ECHO_BYTES-1:0][7:0] echo,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [7:0]                 out_data,
   output logic                       busy
);

   localparam logic [IDX_W-1:0] NEG_LAST = IDX_W'(NEG_BYTES - 1);
   localparam logic [IDX_W-1:0] KA_LAST  = IDX_W'(KA_BYTES - 1);
   localparam logic [IDX_W-1:0] PAD_POS  = IDX_W'(NEG_BYTES - 2);

   logic             active;
   logic [IDX_W-1:0] pos;
   req_kind_t        kind_q;
   logic [IDX_W-1:0] last_pos;

   assign last_pos  = (kind_q == K_NEG) ? NEG_LAST : KA_LAST;
   assign out_valid = active;
   assign busy      = active;

   always_comb begin
      out_data = 8'h00;
      if (kind_q == K_NEG) begin
         if (pos == 0)             out_data = PT_NEG;
         else if (pos == 1)        out_data = 8'(NEG_BYTES - 2);
         else if (pos == 2)        out_data = RPL_NEG_TAG;
         else if (pos >= PAD_POS)  out_data = RPL_PAD;
         else begin
            for (int k = 0; k < ECHO_BYTES; k++)
               if (pos == IDX_W'(ECHO_FIRST + k)) out_data = echo[k];
         end
      end else begin
         case (pos)
            4'd0:    out_data = PT_KA;
            4'd1:    out_data = 8'(KA_BYTES - 2);
            4'd2:    out_data = RPL_KA_ACK;
            default: out_data = 8'h00;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         pos    <= '0;
         kind_q <= K_NEG;
      end else if (load) begin
         active <= 1'b1;
         pos    <= '0;
         kind_q <= kind;
      end else if (active && out_ready) begin
         if (pos == last_pos) active <= 1'b0;
         else                 pos    <= pos + 1'b1;
      end
   end

endmodule

// File: rtl/link_hs_responder.sv
module link_hs_responder
   import link_hs_pkg::*;
#(
   parameter int LEN_W  = 13,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   output logic              pkt_ready,
   input  logic [7:0]        pkt_type,
   input  logic [LEN_W-1:0]  pkt_len,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              err_pulse
);

   // elaboration-time parameter checks
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the request window");
   end
   if ((1 << LEN_W) <= NEG_BYTES) begin : g_bad_len
      $error("LEN_W too narrow for the request length");
   end
   if (ECHO_FIRST + ECHO_BYTES > NEG_BYTES - 2) begin : g_bad_echo
      $error("echo slice overlaps the reply trailer");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_EMIT, ST_RETIRE} st_t;

   st_t                         st;
   logic                        is_req;
   logic                        is_pass;
   req_kind_t                   req_kind;
   logic                        scan_start;
   logic                        scan_done;
   logic                        scan_good;
   logic                        tx_load;
   logic                        tx_busy;
   logic [ECHO_BYTES-1:0][7:0]  echo;

   assign is_req   = (pkt_type == PT_NEG) || (pkt_type == PT_KA);
   assign is_pass  = (pkt_type == PT_CMD) || (pkt_type == PT_ACL) ||
                     (pkt_type == PT_SCO);
   assign req_kind = (pkt_type == PT_KA) ? K_KA : K_NEG;

   assign scan_start = (st == ST_IDLE) && pkt_valid && is_req;
   assign tx_load    = (st == ST_SCAN) && scan_done && scan_good;
   assign pkt_ready  = (st == ST_RETIRE);

   link_hs_scan #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (scan_start),
      .kind    (req_kind),
      .len     (pkt_len),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .done    (scan_done),
      .good    (scan_good),
      .echo    (echo)
   );

   link_hs_reply i_reply (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .kind      (req_kind),
      .echo      (echo),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .busy      (tx_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         err_pulse <= 1'b0;
      end else begin
         err_pulse <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (pkt_valid) begin
                  if (is_req) begin
                     st <= ST_SCAN;
                  end else begin
                     err_pulse <= ~is_pass;
                     st        <= ST_RETIRE;
                  end
               end
            end
            ST_SCAN: begin
               if (scan_done) begin
                  if (scan_good) begin
                     st <= ST_EMIT;
                  end else begin
                     err_pulse <= 1'b1;
                     st        <= ST_RETIRE;
                  end
               end
            end
            ST_EMIT: begin
               if (!tx_busy) st <= ST_RETIRE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/link_hs_responder_chk.sv
module link_hs_responder_chk
   import link_hs_pkg::*;
#(
   parameter int LEN_W  = 13,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pkt_valid,
   input logic              pkt_ready,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [7:0]        out_data,
   input logic              err_pulse
);

   a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);

   a_r7_err_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !out_valid);

   a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   a_r9_retire_drained: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |-> (!out_valid && pkt_valid));

   a_r9_retire_single: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |=> !pkt_ready);

   a_r10_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr < ADDR_W'(NEG_BYTES));

endmodule

bind link_hs_responder link_hs_responder_chk #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pkt_valid (pkt_valid),
   .pkt_ready (pkt_ready),
   .rd_addr   (rd_addr),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .err_pulse (err_pulse)
);

// File: tb/test_link_hs_responder.sv
module test_link_hs_responder;

   localparam int LEN_W  = 13;
   localparam int ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pkt_valid = 1'b0;
   logic              pkt_ready;
   logic [7:0]        pkt_type = 8'h00;
   logic [LEN_W-1:0]  pkt_len = '0;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [7:0]        out_data;
   logic              err_pulse;

   logic [7:0] mem [0:15];
   int checks = 0;
   int errors = 0;
   int err_seen = 0;
   int cyc = 0;
   logic [7:0] exp_q [$];
   bit   rmode = 1'b0;
   bit   hold_low = 1'b0;
   logic [7:0] lfsr = 8'hA5;
   bit   prev_stall = 1'b0;
   logic [7:0] prev_data = 8'h00;
   bit   done_flag = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   assign rd_data = (rd_addr < 16) ? mem[rd_addr[3:0]] : 8'hEE;

   link_hs_responder #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_link_hs_responder (
      .clk (clk), .rst_n (rst_n), .pkt_valid (pkt_valid), .pkt_ready (pkt_ready),
      .pkt_type (pkt_type), .pkt_len (pkt_len), .rd_addr (rd_addr), .rd_data (rd_data),
      .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
      .err_pulse (err_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic print_summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc >= 60000 && !done_flag) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         print_summary();
         $finish;
      end
   end

   // per-cycle model comparison, away from the active edge
   always @(negedge clk) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = hold_low ? 1'b0 : (rmode ? (lfsr[0] | lfsr[3]) : 1'b1);
      if (rst_n) begin
         if (prev_stall)
            check(out_valid && out_data == prev_data, "R8", out_data, prev_data);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0)
               check(1'b0, "R9 unexpected byte", out_data, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(out_data == e, "R2/R4 reply byte", out_data, e);
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         if (err_pulse) err_seen++;
         if (rd_addr > 11) check(1'b0, "R10", rd_addr, 11);
      end
   end

   function automatic bit neg_ok(input int len);
      logic [7:0] pat [0:11];
      pat = '{8'h06, 8'h0A, 8'h00, 8'hA0, 8'h01, 8'h00, 8'h00, 8'h4C, 8'h00, 8'h96, 8'h00, 8'h00};
      if (len != 12) return 1'b0;
      for (int i = 0; i < 12; i++) if (mem[i] != pat[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic load_neg();
      mem[0] = 8'h06; mem[1] = 8'h0A; mem[2] = 8'h00; mem[3] = 8'hA0;
      mem[4] = 8'h01; mem[5] = 8'h00; mem[6] = 8'h00; mem[7] = 8'h4C;
      mem[8] = 8'h00; mem[9] = 8'h96; mem[10] = 8'h00; mem[11] = 8'h00;
   endtask

   task automatic load_ka(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
      mem[0] = 8'h07; mem[1] = b1; mem[2] = b2; mem[3] = b3;
   endtask

   // model: build expected reply and error, present packet, wait for retire
   task automatic run_pkt(input logic [7:0] ty, input int len, input string req);
      bit exp_err;
      int e0;
      int waited;
      exp_err = 1'b0;
      if (ty == 8'h06) begin
         if (neg_ok(len)) begin
            exp_q.push_back(8'h06); exp_q.push_back(8'h0A); exp_q.push_back(8'h20);
            for (int i = 3; i <= 9; i++) exp_q.push_back(mem[i]);
            exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
         end else exp_err = 1'b1;
      end else if (ty == 8'h07) begin
         if (len == 4 && mem[2] == 8'h55 && mem[3] == 8'h00) begin
            exp_q.push_back(8'h07); exp_q.push_back(8'h02);
            exp_q.push_back(8'hCC); exp_q.push_back(8'h00);
         end else exp_err = 1'b1;
      end else if (!(ty == 8'h01 || ty == 8'h02 || ty == 8'h03)) begin
         exp_err = 1'b1;
      end
      @(negedge clk);
      e0 = err_seen;
      pkt_type  = ty;
      pkt_len   = LEN_W'(len);
      pkt_valid = 1'b1;
      waited = 0;
      do begin
         @(negedge clk);
         waited++;
      end while (!pkt_ready && waited < 400);
      check(pkt_ready, {req, " retire"}, pkt_ready, 1);
      check(exp_q.size() == 0 && !out_valid, "R9 drained before retire", exp_q.size(), 0);
      @(posedge clk);
      #1 pkt_valid = 1'b0;
      check((err_seen - e0) == (exp_err ? 1 : 0), {req, "/R7 error pulses"},
            err_seen - e0, exp_err ? 1 : 0);
      exp_q.delete();
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(!out_valid && !pkt_ready && !err_pulse, "R1 reset state",
            {out_valid, pkt_ready, err_pulse}, 0);

      load_neg();
      run_pkt(8'h06, 12, "R2");                 // R2 plain
      rmode = 1'b1;
      run_pkt(8'h06, 12, "R2");                 // R2 with random backpressure
      load_neg(); mem[7] = 8'h4D;
      run_pkt(8'h06, 12, "R3");                 // R3 mid byte
      load_neg(); mem[0] = 8'h07;
      run_pkt(8'h06, 12, "R3");                 // R3 type byte in buffer
      load_neg(); mem[11] = 8'h01;
      run_pkt(8'h06, 12, "R3");                 // R3 last byte
      load_neg();
      run_pkt(8'h06, 11, "R3");                 // R3 short length
      run_pkt(8'h06, 13, "R3");                 // R3 long length

      load_ka(8'h3C, 8'h55, 8'h00);
      run_pkt(8'h07, 4, "R4");                  // R4, byte 1 arbitrary
      load_ka(8'h00, 8'h54, 8'h00);
      run_pkt(8'h07, 4, "R5");
      load_ka(8'h00, 8'h55, 8'h01);
      run_pkt(8'h07, 4, "R5");
      load_ka(8'h00, 8'h55, 8'h00);
      run_pkt(8'h07, 5, "R5");

      run_pkt(8'h04, 3, "R6 event");
      run_pkt(8'h01, 4, "R6 command");
      run_pkt(8'h02, 5, "R6 acl");
      run_pkt(8'h03, 4, "R6 sco");
      run_pkt(8'h09, 2, "R6 unknown");
      run_pkt(8'h05, 2, "R6 unknown");

      // long stall mid-reply, R8 and R9
      load_neg();
      fork
         run_pkt(8'h06, 12, "R9 stalled");
         begin
            repeat (6) @(negedge clk);
            hold_low = 1'b1;
            repeat (20) @(negedge clk);
            check(out_valid && !pkt_ready, "R9 held while stalled", {out_valid, pkt_ready}, 2);
            hold_low = 1'b0;
         end
      join
      load_ka(8'hFF, 8'h55, 8'h00);
      run_pkt(8'h07, 4, "R4");

      repeat (4) @(negedge clk);
      check(!out_valid && !err_pulse, "R7 idle at end", {out_valid, err_pulse}, 0);
      done_flag = 1'b1;
      print_summary();
      $finish;
   end

endmodule